// File: doc/BRIEF.md
# Serial Host Control Port

This block is the slave side of a four-wire host port for a line-interface device. A host selects the device by pulling chip select low, toggles a serial clock, and sends a command byte followed by a data byte, both least significant bit first. The command carries a read/write flag and a six-bit device address. Only one address is answered. A write loads the line-length, loopback and all-ones controls and can clear the interrupt latches. A read returns the control bits and the latch states on a serial output that is enabled only during the data phase.

The serial pins are oversampled by the system clock through two-flop synchronizers, so the serial clock must run well below the system clock. Two status inputs, loss of signal and driver fault, set sticky latches that drive an interrupt output until the host clears them.

Top module: `serial_ctrl_port`

## Requirements
- R1: After reset, `line_len`, `rem_loop`, `loc_loop`, `tx_ones`, `test_mode`, `irq` and `sdo_oe` are all 0.
- R2: A transfer is framed by `cs_n` low and sampled on rising `sclk` edges. Rising edges 1 to 8 carry the command and rising edges 9 to 16 carry the data byte, both LSB first. A completed write loads data bits 4:2 into `line_len`, bit 5 into `rem_loop`, bit 6 into `loc_loop` and bit 7 into `tx_ones`.
- R3: Command bit 0 selects the operation (0 write, 1 read), and command bit 7 has no effect. A transfer is answered only when command bit 6 is 1 and bits 5:1 are 0. Any other address leaves the outputs unchanged and keeps `sdo_oe` low.
- R4: A write whose `cs_n` rises before the 16th rising edge changes nothing.
- R5: A high `los_in` or `drv_fault_in` sets its own sticky latch. `irq` is high while either latch is set.
- R6: A completed write with data bit 0 set clears the loss-of-signal latch, and with data bit 1 set clears the driver-fault latch. A 0 in either bit leaves that latch alone.
- R7: `test_mode` is 1 exactly when the stored data bits 7:5 are 101 or 111.
- R8: With `edge_sel` = 1, read bit i is driven from falling edge 8+i. Bit 7 is held until falling edge 16, after which `sdo_oe` is low.
- R9: With `edge_sel` = 0, read bit i is driven from rising edge 9+i. Bit 7 is held until rising edge 17, after which `sdo_oe` is low.
- R10: Raising `cs_n` during a read disables `sdo_oe` within a few system clocks.
- R11: A read returns, LSB first, bit 0 = loss-of-signal latch, bit 1 = driver-fault latch, and bits 7:2 = the stored control bits. The byte is captured at the end of the command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from host |
| sdi | input | 1 | Serial data from host |
| edge_sel | input | 1 | Read launch edge: 1 falling, 0 rising |
| los_in | input | 1 | Loss-of-signal event |
| drv_fault_in | input | 1 | Driver fault event |
| sdo | output | 1 | Serial read data |
| sdo_oe | output | 1 | Output enable for the sdo pad |
| line_len | output | 3 | Line length select |
| rem_loop | output | 1 | Remote loopback enable |
| loc_loop | output | 1 | Local loopback enable |
| tx_ones | output | 1 | Transmit all ones |
| test_mode | output | 1 | Test mode combination decoded |
| irq | output | 1 | Interrupt, high while a latch is set |

## Verification
The hardest case to reach is the end of the hold window for the last read bit. It lies on a different edge for each `edge_sel` value and only one serial edge away from a normal data bit. The bench therefore samples `sdo` and `sdo_oe` just before every rising and every falling edge of a 17-clock read, in both edge modes, and checks the exact edge at which the enable drops. A second awkward case is a latch cleared by a write while its source is quiet. The bench reaches it by pulsing each status input once, then issuing writes that clear one latch at a time.

// File: rtl/serial_ctrl_port.sv
`timescale 1ns/1ps
module serial_ctrl_port #(
  parameter int          SYNC_STAGES = 2,
  parameter logic [5:0]  DEV_ADDR    = 6'b100000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sclk,
  input  logic       sdi,
  input  logic       edge_sel,
  input  logic       los_in,
  input  logic       drv_fault_in,
  output logic       sdo,
  output logic       sdo_oe,
  output logic [2:0] line_len,
  output logic       rem_loop,
  output logic       loc_loop,
  output logic       tx_ones,
  output logic       test_mode,
  output logic       irq
);
  logic [SYNC_STAGES-1:0] cs_q, sck_q, sdi_q;
  logic       sck_d;
  logic [4:0] rcnt, fcnt;
  logic [7:0] cmd, dat, rd_byte;
  logic [5:0] ctrl;
  logic       hit_rd, hit_wr, los_lat, drv_lat;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_q  <= '1;
      sck_q <= '0;
      sdi_q <= '0;
      sck_d <= 1'b0;
    end else begin
      cs_q  <= {cs_q[SYNC_STAGES-2:0], cs_n};
      sck_q <= {sck_q[SYNC_STAGES-2:0], sclk};
      sdi_q <= {sdi_q[SYNC_STAGES-2:0], sdi};
      sck_d <= sck_q[SYNC_STAGES-1];
    end

  wire cs_s  = cs_q[SYNC_STAGES-1];
  wire sck_s = sck_q[SYNC_STAGES-1];
  wire sdi_s = sdi_q[SYNC_STAGES-1];
  wire rise  = sck_s & ~sck_d & ~cs_s;
  wire fall  = ~sck_s & sck_d & ~cs_s;

  wire [7:0] cmd_nx  = {sdi_s, cmd[7:1]};
  wire [7:0] dat_nx  = {sdi_s, dat[7:1]};
  wire       addr_ok = (cmd_nx[6:1] == DEV_ADDR);
  wire       commit  = rise & hit_wr & (rcnt == 5'd15);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rcnt    <= '0;
      fcnt    <= '0;
      cmd     <= '0;
      dat     <= '0;
      rd_byte <= '0;
      hit_rd  <= 1'b0;
      hit_wr  <= 1'b0;
    end else if (cs_s) begin
      rcnt   <= '0;
      fcnt   <= '0;
      hit_rd <= 1'b0;
      hit_wr <= 1'b0;
    end else begin
      if (rise) begin
        if (rcnt != 5'd31) rcnt <= rcnt + 5'd1;
        if (rcnt < 5'd8) cmd <= cmd_nx;
        if (rcnt == 5'd7) begin
          hit_rd  <= addr_ok & cmd_nx[0];
          hit_wr  <= addr_ok & ~cmd_nx[0];
          rd_byte <= {ctrl, drv_lat, los_lat};
        end
        if (rcnt >= 5'd8 && rcnt < 5'd16) dat <= dat_nx;
      end
      if (fall && fcnt != 5'd31) fcnt <= fcnt + 5'd1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctrl    <= '0;
      los_lat <= 1'b0;
      drv_lat <= 1'b0;
    end else begin
      if (commit) ctrl <= dat_nx[7:2];
      los_lat <= los_in       | (los_lat & ~(commit & dat_nx[0]));
      drv_lat <= drv_fault_in | (drv_lat & ~(commit & dat_nx[1]));
    end

  wire [4:0] rofs   = rcnt - 5'd9;
  wire       rd_win = edge_sel ? (fcnt >= 5'd8 && fcnt <= 5'd15)
                               : (rcnt >= 5'd9 && rcnt <= 5'd16);
  wire [2:0] idx    = edge_sel ? fcnt[2:0] : rofs[2:0];

  assign sdo_oe    = hit_rd & ~cs_s & rd_win;
  assign sdo       = sdo_oe & rd_byte[idx];
  assign line_len  = ctrl[2:0];
  assign rem_loop  = ctrl[3];
  assign loc_loop  = ctrl[4];
  assign tx_ones   = ctrl[5];
  assign test_mode = ctrl[5] & ctrl[3];
  assign irq       = los_lat | drv_lat;
endmodule

module serial_ctrl_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       los_in,
  input logic       drv_fault_in,
  input logic       sdo_oe,
  input logic [2:0] line_len,
  input logic       rem_loop,
  input logic       loc_loop,
  input logic       tx_ones,
  input logic       irq
);
  a_r10_idle_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n && $past(cs_n) && $past(cs_n, 2) |-> !sdo_oe);

  a_r2_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)
    |-> $stable({line_len, rem_loop, loc_loop, tx_ones}));

  a_r5_los_sets: assert property (@(posedge clk) disable iff (!rst_n)
    los_in |=> irq);

  a_r5_drv_sets: assert property (@(posedge clk) disable iff (!rst_n)
    drv_fault_in |=> irq);

  a_r6_clear_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(!los_in && !drv_fault_in));
endmodule

bind serial_ctrl_port serial_ctrl_port_chk u_chk (.*);

// File: tb/serial_ctrl_port_tb.sv
`timescale 1ns/1ps
module serial_ctrl_port_tb;
  localparam int H = 10;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0, edge_sel = 1'b1;
  logic los_in = 1'b0, drv_fault_in = 1'b0;
  logic sdo, sdo_oe, rem_loop, loc_loop, tx_ones, test_mode, irq;
  logic [2:0] line_len;
  int tests = 0, fails = 0;
  bit done = 0;
  logic oe_lo [0:17], oe_hi [0:17], sd_lo [0:17], sd_hi [0:17];

  always #2.5 clk = ~clk;

  serial_ctrl_port u_dut (.*);

  // {cmd, data, expected control bits 7:2, expected test flag}
  localparam logic [22:0] VEC [8] = '{
    {8'h40, 8'h1C, 6'b000111, 1'b0},
    {8'hC0, 8'hA0, 6'b101000, 1'b1},
    {8'h42, 8'hFC, 6'b101000, 1'b1},
    {8'h40, 8'hE4, 6'b111001, 1'b1},
    {8'h40, 8'h40, 6'b010000, 1'b0},
    {8'h00, 8'h08, 6'b010000, 1'b0},
    {8'h40, 8'h28, 6'b001010, 1'b0},
    {8'h40, 8'h80, 6'b100000, 1'b0}
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] cmd, input logic [7:0] data, input int ncyc, input logic sel);
    logic [15:0] frame;
    frame = {data, cmd};
    for (int k = 0; k < 18; k++) begin
      oe_lo[k] = 1'b0; oe_hi[k] = 1'b0; sd_lo[k] = 1'b0; sd_hi[k] = 1'b0;
    end
    @(negedge clk);
    edge_sel = sel;
    cs_n = 1'b0;
    repeat (H) @(negedge clk);
    for (int k = 1; k <= ncyc; k++) begin
      sclk = 1'b0;
      sdi = (k <= 16) ? frame[k-1] : 1'b0;
      repeat (H - 1) @(negedge clk);
      oe_lo[k] = sdo_oe; sd_lo[k] = sdo;
      @(negedge clk);
      sclk = 1'b1;
      repeat (H - 1) @(negedge clk);
      oe_hi[k] = sdo_oe; sd_hi[k] = sdo;
      @(negedge clk);
    end
    sclk = 1'b0;
    repeat (H) @(negedge clk);
    cs_n = 1'b1;
    repeat (H) @(negedge clk);
  endtask

  function automatic logic [7:0] rd_val(input logic sel);
    logic [7:0] v;
    for (int i = 0; i < 8; i++) v[i] = sel ? sd_lo[9+i] : sd_hi[9+i];
    return v;
  endfunction

  function automatic logic [5:0] ctrl_out();
    return {tx_ones, loc_loop, rem_loop, line_len};
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic any;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1", "controls", {26'd0, ctrl_out()}, 32'd0);
    chk("R1", "test_mode", test_mode, 0);
    chk("R1", "irq", irq, 0);
    chk("R1", "sdo_oe", sdo_oe, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 R3 R7 vector walk
    foreach (VEC[i]) begin
      xfer(VEC[i][22:15], VEC[i][14:7], 16, 1'b1);
      chk("R2/R3", "controls", {26'd0, ctrl_out()}, {26'd0, VEC[i][6:1]});
      chk("R7", "test_mode", test_mode, VEC[i][0]);
    end

    // R8 read, falling-edge launch
    xfer(8'h40, 8'h74, 16, 1'b1);
    xfer(8'h41, 8'h00, 17, 1'b1);
    chk("R11", "read byte sel1", rd_val(1'b1), 8'h74);
    chk("R8", "oe before fall 8", oe_lo[8], 0);
    chk("R8", "oe after fall 8", oe_lo[9], 1);
    chk("R8", "oe holds D7", oe_lo[16], 1);
    chk("R8", "oe after fall 16", oe_lo[17], 0);

    // R9 read, rising-edge launch
    xfer(8'h41, 8'h00, 17, 1'b0);
    chk("R9", "read byte sel0", rd_val(1'b0), 8'h74);
    chk("R9", "oe before rise 9", oe_lo[9], 0);
    chk("R9", "oe holds D7 past fall 16", oe_lo[17], 1);
    chk("R9", "oe after rise 17", oe_hi[17], 0);

    // R3 read at wrong address, command bit 7 ignored on read
    xfer(8'h43, 8'h00, 17, 1'b0);
    any = 1'b0;
    for (int k = 1; k <= 17; k++) any = any | oe_lo[k] | oe_hi[k];
    chk("R3", "oe on foreign address", any, 0);
    xfer(8'hC1, 8'h00, 17, 1'b1);
    chk("R3", "bit7 ignored on read", rd_val(1'b1), 8'h74);

    // R10 chip select ends read early
    xfer(8'h41, 8'h00, 12, 1'b0);
    chk("R10", "oe mid read", oe_hi[12], 1);
    chk("R10", "oe after cs high", sdo_oe, 0);

    // R4 truncated write
    xfer(8'h40, 8'h00, 12, 1'b1);
    chk("R4", "controls after cut write", {26'd0, ctrl_out()}, {26'd0, 6'b011101});

    // R5 R6 interrupt latches
    @(negedge clk); los_in = 1'b1; @(negedge clk); los_in = 1'b0;
    repeat (20) @(negedge clk);
    chk("R5", "irq sticky after los", irq, 1);
    xfer(8'h41, 8'h00, 17, 1'b1);
    chk("R11", "read shows los latch", rd_val(1'b1), 8'h75);
    xfer(8'h40, 8'h76, 16, 1'b1);
    chk("R6", "drv clear leaves los", irq, 1);
    xfer(8'h40, 8'h75, 16, 1'b1);
    chk("R6", "los clear", irq, 0);
    @(negedge clk); drv_fault_in = 1'b1; @(negedge clk); drv_fault_in = 1'b0;
    repeat (20) @(negedge clk);
    chk("R5", "irq sticky after drv fault", irq, 1);
    xfer(8'h41, 8'h00, 17, 1'b0);
    chk("R11", "read shows drv latch", rd_val(1'b0), 8'h76);
    xfer(8'h40, 8'h75, 16, 1'b1);
    chk("R6", "los clear leaves drv", irq, 1);
    xfer(8'h40, 8'h76, 16, 1'b1);
    chk("R6", "drv clear", irq, 0);
    chk("R2", "controls kept", {26'd0, ctrl_out()}, {26'd0, 6'b011101});

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule